// File: doc/BRIEF.md
# Line Pixel Statistics Unit

This block watches a stream of digitised pixel samples belonging to one sensor line and, once the line is closed, reports three quality figures over the samples marked valid. The first is the line mean, with a fixed number of pixels as the divisor. The second is the largest distance of any contributing pixel from that mean. The third is that distance expressed as a whole-number percentage of the mean.

Samples enter on `smp_data` with a `smp_valid` qualifier. A `smp_eol` strobe closes the line, and it may coincide with the last valid sample. The mean is only known after the line closes, so the block keeps a running sum, minimum and maximum while samples arrive. It then resolves the mean and the percentage with one shared bit-serial divider. While that runs, `busy` is high and the inputs are ignored. The results appear together with a one-cycle `done` pulse and hold until the next pulse. The next line may start in the cycle that carries `done`.

Top module: `line_stats_unit`

## Requirements
- R1: A sample contributes only in a cycle where `smp_valid` is 1 and `busy` is 0. The data bus is ignored whenever `smp_valid` is 0.
- R2: A cycle with `smp_eol` = 1 and `busy` = 0 closes the line. A valid sample in that same cycle still belongs to the closing line. An end strobe with no valid sample also closes the line, and an end strobe with zero samples gives an empty line.
- R3: `avg_out` is the floor of the sum of the contributing samples divided by LINE_PIXELS.
- R4: `dev_out` is the larger of (max − avg) and (avg − min), each clamped at 0, over the contributing samples. The running min starts at full scale and the running max starts at 0 for every line.
- R5: When the mean is non-zero, `pct_out` is the floor of dev × 100 / avg.
- R6: When the mean is zero, `pct_out` is all ones and `zero_avg_err` is 1. Otherwise `zero_avg_err` is 0.
- R7: `count_err` is 1 when the number of valid samples in the line differs from LINE_PIXELS. Results are still reported in that case, and only the first LINE_PIXELS valid samples of a line contribute.
- R8: `busy` rises in the cycle after an accepted end strobe and stays high until `done`. Samples and end strobes seen while `busy` is high have no effect.
- R9: `done` is a single-cycle pulse during which `busy` is 0. All outputs hold their values between pulses, and a sample offered in the `done` cycle is accepted as the first sample of the next line.
- R10: After reset, `busy`, `done`, `avg_out`, `dev_out`, `pct_out`, `zero_avg_err` and `count_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Sample on `smp_data` is a valid pixel |
| smp_eol | input | 1 | Closes the current line |
| smp_data | input | PIX_W | Unsigned pixel value |
| busy | output | 1 | Statistics being resolved, inputs ignored |
| done | output | 1 | One-cycle pulse, results updated |
| avg_out | output | PIX_W | Line mean |
| dev_out | output | PIX_W | Largest deviation from the mean |
| pct_out | output | PIX_W+7 | Deviation as a percentage of the mean |
| zero_avg_err | output | 1 | Mean was zero, percentage saturated |
| count_err | output | 1 | Valid sample count differed from LINE_PIXELS |

## Verification
Two functions can fall in the same cycle: the `done` pulse that finishes one line, and the acceptance of the first sample of the next line. The same holds for the closing strobe and the last valid pixel. The stimulus offers the next line's first sample as soon as the previous end strobe is taken. That sample waits through the whole busy window and is accepted exactly on the `done` edge. The check is that every line's mean, deviation, percentage and flags match the arithmetic model. It also checks that `done` lasts one cycle, so the sample is neither lost, counted twice, nor mixed into the earlier line.

// File: rtl/line_stats_pkg.sv
// Shared definitions for the line pixel statistics unit.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package line_stats_pkg;

    // Sequencer states: collect samples, then resolve the results step by step.
    typedef enum logic [2:0] {
        ST_COLLECT  = 3'd0,
        ST_AVG_GO   = 3'd1,
        ST_AVG_WAIT = 3'd2,
        ST_DEV      = 3'd3,
        ST_PCT_WAIT = 3'd4,
        ST_FINISH   = 3'd5
    } stat_state_e;

    // Larger of two integers, used to size shared datapaths.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/line_stats_accum.sv
// Running accumulator for one line: sum, minimum, maximum and valid count.
// When the line closes, it takes a snapshot that includes any sample offered
// in that same cycle, then restarts for the next line.
// Assumes: take_i and finish_i are already gated by the caller's busy state.
//          SUM_W holds LINE_PIXELS full-scale samples, and CNT_W holds LINE_PIXELS+1.
module line_stats_accum #(
    parameter int PIX_W       = 12,
    parameter int LINE_PIXELS = 5400,
    parameter int SUM_W       = PIX_W + $clog2(LINE_PIXELS + 1),
    parameter int CNT_W       = $clog2(LINE_PIXELS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic             finish_i,
    input  logic [PIX_W-1:0] pix_i,
    output logic [SUM_W-1:0] snap_sum_o,
    output logic [PIX_W-1:0] snap_min_o,
    output logic [PIX_W-1:0] snap_max_o,
    output logic [CNT_W-1:0] snap_cnt_o
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LINE_PIXELS);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(LINE_PIXELS + 1);
    localparam logic [PIX_W-1:0] PIX_FS   = '1;

    logic [SUM_W-1:0] sum_r,  sum_nx;
    logic [PIX_W-1:0] min_r,  min_nx;
    logic [PIX_W-1:0] max_r,  max_nx;
    logic [CNT_W-1:0] cnt_r,  cnt_nx;
    logic             use_pix;

    // Next running values, including the sample offered this cycle.
    always_comb begin
        use_pix = take_i && (cnt_r < CNT_FULL);
        sum_nx  = use_pix ? (sum_r + SUM_W'(pix_i)) : sum_r;
        min_nx  = (use_pix && (pix_i < min_r)) ? pix_i : min_r;
        max_nx  = (use_pix && (pix_i > max_r)) ? pix_i : max_r;
        cnt_nx  = (take_i && (cnt_r != CNT_OVER)) ? (cnt_r + 1'b1) : cnt_r;
    end

    // Running state update, and snapshot plus restart at line close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_r      <= '0;
            min_r      <= PIX_FS;
            max_r      <= '0;
            cnt_r      <= '0;
            snap_sum_o <= '0;
            snap_min_o <= '0;
            snap_max_o <= '0;
            snap_cnt_o <= '0;
        end else if (finish_i) begin
            snap_sum_o <= sum_nx;
            snap_min_o <= min_nx;
            snap_max_o <= max_nx;
            snap_cnt_o <= cnt_nx;
            sum_r      <= '0;
            min_r      <= PIX_FS;
            max_r      <= '0;
            cnt_r      <= '0;
        end else begin
            sum_r <= sum_nx;
            min_r <= min_nx;
            max_r <= max_nx;
            cnt_r <= cnt_nx;
        end
    end

    // Once a pixel has contributed, the running minimum cannot exceed the maximum.
    AST_MIN_LE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_r != '0) |-> (min_r <= max_r)); // R4

    // The valid count saturates just past the line length.
    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_r <= CNT_OVER)); // R7

    // Once the line is full, further samples leave the sum unchanged.
    AST_SUM_FROZEN_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_r >= CNT_FULL) && !finish_i) |=> $stable(sum_r)); // R7

endmodule

// File: rtl/line_stats_div.sv
// Bit-serial restoring divider. It produces one quotient bit per cycle and
// finishes NUM_W cycles after start.
// Assumes: den_i is non-zero when start_i is high, and start_i only arrives while idle.
module line_stats_div #(
    parameter int NUM_W = 25,
    parameter int DEN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o
);

    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [DEN_W:0]    rem_r;
    logic [DEN_W-1:0]  den_r;
    logic [STEP_W-1:0] steps_r;
    logic [DEN_W:0]    shifted;
    logic              fits;

    // Shift the next dividend bit into the partial remainder and test it.
    always_comb begin
        shifted = {rem_r[DEN_W-1:0], quo_o[NUM_W-1]};
        fits    = (shifted >= {1'b0, den_r});
    end

    // Load the operands on start, then take one restoring step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_r   <= '0;
            den_r   <= '0;
            quo_o   <= '0;
            steps_r <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                rem_r   <= '0;
                den_r   <= den_i;
                quo_o   <= num_i;
                steps_r <= STEP_W'(NUM_W);
            end else if (steps_r != '0) begin
                rem_r   <= fits ? (shifted - {1'b0, den_r}) : shifted;
                quo_o   <= {quo_o[NUM_W-2:0], fits};
                steps_r <= steps_r - 1'b1;
                done_o  <= (steps_r == STEP_W'(1));
            end
        end
    end

    assign busy_o = (steps_r != '0);

    // While working, the partial remainder stays below the divisor.
    AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (rem_r < {1'b0, den_r})); // R3

    // A new operation is never requested while one is still running.
    AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o); // R5

    // Completion always follows a working cycle.
    AST_DIV_DONE_AFTER_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o)); // R5

endmodule

// File: rtl/line_stats_unit.sv
// Line pixel statistics unit. It accumulates the valid pixels of a line, then
// resolves the mean, the largest deviation from the mean and the
// percentage non-uniformity. It uses one shared serial divider and reports
// everything with a done pulse.
// Assumes: an end strobe closes the line. While busy, all inputs are ignored.
module line_stats_unit #(
    parameter int PIX_W       = 12,
    parameter int LINE_PIXELS = 5400
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic                 smp_eol,
    input  logic [PIX_W-1:0]     smp_data,
    output logic                 busy,
    output logic                 done,
    output logic [PIX_W-1:0]     avg_out,
    output logic [PIX_W-1:0]     dev_out,
    output logic [PIX_W+6:0]     pct_out,
    output logic                 zero_avg_err,
    output logic                 count_err
);
    import line_stats_pkg::*;

    localparam int SUM_W = PIX_W + $clog2(LINE_PIXELS + 1);
    localparam int CNT_W = $clog2(LINE_PIXELS + 2);
    localparam int PCT_W = PIX_W + 7;
    localparam int DEN_W = imax(PIX_W, $clog2(LINE_PIXELS + 1));
    localparam int NUM_W = imax(SUM_W, PCT_W);

    stat_state_e      state_r;
    logic             take, finish;
    logic [SUM_W-1:0] snap_sum;
    logic [PIX_W-1:0] snap_min, snap_max;
    logic [CNT_W-1:0] snap_cnt;
    logic             div_start, div_busy, div_done;
    logic [NUM_W-1:0] div_num, div_quo;
    logic [DEN_W-1:0] div_den;
    logic [PIX_W-1:0] avg_r, dev_r, dev_c, dev_hi, dev_lo;
    logic [PCT_W-1:0] pct_r, pct_num;
    logic             zero_r;

    // Accept inputs only while the sequencer is collecting.
    always_comb begin
        busy   = (state_r != ST_COLLECT);
        take   = smp_valid && !busy;
        finish = smp_eol && !busy;
    end

    line_stats_accum #(
        .PIX_W(PIX_W), .LINE_PIXELS(LINE_PIXELS), .SUM_W(SUM_W), .CNT_W(CNT_W)
    ) u_accum (
        .clk(clk), .rst_n(rst_n), .take_i(take), .finish_i(finish), .pix_i(smp_data),
        .snap_sum_o(snap_sum), .snap_min_o(snap_min), .snap_max_o(snap_max),
        .snap_cnt_o(snap_cnt)
    );

    // Deviation from the resolved mean, each side clamped at zero.
    always_comb begin
        dev_hi  = (snap_max >= avg_r) ? (snap_max - avg_r) : '0;
        dev_lo  = (avg_r >= snap_min) ? (avg_r - snap_min) : '0;
        dev_c   = (dev_hi > dev_lo) ? dev_hi : dev_lo;
        pct_num = PCT_W'(dev_c) * PCT_W'(100);
    end

    // Divider operand selection: the mean first, then the percentage.
    always_comb begin
        div_start = (state_r == ST_AVG_GO) || ((state_r == ST_DEV) && (avg_r != '0));
        if (state_r == ST_AVG_GO) begin
            div_num = NUM_W'(snap_sum);
            div_den = DEN_W'(LINE_PIXELS);
        end else begin
            div_num = NUM_W'(pct_num);
            div_den = DEN_W'(avg_r);
        end
    end

    line_stats_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start_i(div_start), .num_i(div_num), .den_i(div_den),
        .busy_o(div_busy), .done_o(div_done), .quo_o(div_quo)
    );

    // Sequencer: close the line, resolve the mean, deviation and percentage, then publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_r      <= ST_COLLECT;
            avg_r        <= '0;
            dev_r        <= '0;
            pct_r        <= '0;
            zero_r       <= 1'b0;
            done         <= 1'b0;
            avg_out      <= '0;
            dev_out      <= '0;
            pct_out      <= '0;
            zero_avg_err <= 1'b0;
            count_err    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_r)
                ST_COLLECT:  if (finish) state_r <= ST_AVG_GO;
                ST_AVG_GO:   state_r <= ST_AVG_WAIT;
                ST_AVG_WAIT: if (div_done) begin
                    avg_r   <= div_quo[PIX_W-1:0];
                    state_r <= ST_DEV;
                end
                ST_DEV: begin
                    dev_r <= dev_c;
                    if (avg_r == '0) begin
                        pct_r   <= '1;
                        zero_r  <= 1'b1;
                        state_r <= ST_FINISH;
                    end else begin
                        zero_r  <= 1'b0;
                        state_r <= ST_PCT_WAIT;
                    end
                end
                ST_PCT_WAIT: if (div_done) begin
                    pct_r   <= div_quo[PCT_W-1:0];
                    state_r <= ST_FINISH;
                end
                ST_FINISH: begin
                    avg_out      <= avg_r;
                    dev_out      <= dev_r;
                    pct_out      <= pct_r;
                    zero_avg_err <= zero_r;
                    count_err    <= (snap_cnt != CNT_W'(LINE_PIXELS));
                    done         <= 1'b1;
                    state_r      <= ST_COLLECT;
                end
                default: state_r <= ST_COLLECT;
            endcase
        end
    end

    // An accepted end strobe makes the unit busy on the next cycle.
    AST_EOL_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_eol && !busy) |=> busy); // R8

    // Done is only ever the last step of a busy window.
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy)); // R9

    // Done never lasts more than one cycle.
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    // Published results do not move between done pulses.
    AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(avg_out) && $stable(dev_out) && $stable(pct_out))); // R9

    // A zero mean always comes with a saturated percentage.
    AST_ZERO_AVG_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        zero_avg_err |-> ((avg_out == '0) && (pct_out == '1))); // R6

    // The divider is only active while the unit reports busy.
    AST_DIV_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> busy); // R8

endmodule

// File: tb/line_stats_unit_test.sv
// Self-checking bench for line_stats_unit on a small configuration:
// 4-bit pixels and 6 pixels per line. Expected results are computed arithmetically.
module line_stats_unit_test;

    localparam int PW    = 4;
    localparam int LP    = 6;
    localparam int FS    = 15;
    localparam int SAT   = 2047;
    localparam int LIMIT = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic          smp_eol = 1'b0;
    logic [PW-1:0] smp_data = '0;
    logic          busy, done, zero_avg_err, count_err;
    logic [PW-1:0] avg_out, dev_out;
    logic [PW+6:0] pct_out;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int exp_avg[0:127], exp_dev[0:127], exp_pct[0:127], exp_zero[0:127], exp_cerr[0:127];
    int wr = 0, rd = 0;
    int it_d[0:31], it_v[0:31];
    int n_it;
    bit eol_alone;
    bit prev_done = 1'b0;
    int unsigned seed = 32'h1234_5678;

    line_stats_unit #(.PIX_W(PW), .LINE_PIXELS(LP)) uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_eol(smp_eol),
        .smp_data(smp_data), .busy(busy), .done(done), .avg_out(avg_out),
        .dev_out(dev_out), .pct_out(pct_out), .zero_avg_err(zero_avg_err),
        .count_err(count_err)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Offer one input cycle and hold it until the unit is not busy.
    task automatic put(input bit v, input bit e, input int d);
        @(negedge clk);
        smp_valid = v; smp_eol = e; smp_data = PW'(d);
        while (busy && cyc < LIMIT) @(negedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        smp_valid = 1'b0; smp_eol = 1'b0; smp_data = '0;
    endtask

    // Arithmetic model, then drive the stored line items.
    task automatic send_line();
        int cnt = 0, sum = 0, mn = FS, mx = 0, nv = 0, avg, hi, lo, dev;
        for (int i = 0; i < n_it; i++) begin
            if (it_v[i] != 0) begin
                nv++;
                if (cnt < LP) begin
                    sum += it_d[i];
                    if (it_d[i] < mn) mn = it_d[i];
                    if (it_d[i] > mx) mx = it_d[i];
                    cnt++;
                end
            end
        end
        avg = sum / LP;
        hi  = (mx >= avg) ? mx - avg : 0;
        lo  = (avg >= mn) ? avg - mn : 0;
        dev = (hi > lo) ? hi : lo;
        exp_avg[wr]  = avg;
        exp_dev[wr]  = dev;
        exp_zero[wr] = (avg == 0);
        exp_pct[wr]  = (avg == 0) ? SAT : (dev * 100) / avg;
        exp_cerr[wr] = (nv != LP);
        wr++;
        for (int i = 0; i < n_it; i++)
            put(it_v[i] != 0, (i == n_it - 1) && !eol_alone, it_d[i]);
        if (eol_alone) put(1'b0, 1'b1, 0);
    endtask

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[19:16]);
    endfunction

    // Result monitor: each done pulse is compared against the model in order.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) check("R9 done lasts one cycle", done, 0);
            if (done) begin
                check("R9 busy low with done", busy, 0);
                if (rd < wr) begin
                    check("R3 mean (R1/R2 stimulus)", avg_out, exp_avg[rd]);
                    check("R4 deviation", dev_out, exp_dev[rd]);
                    check("R5 percentage", pct_out, exp_pct[rd]);
                    check("R6 zero-mean flag", zero_avg_err, exp_zero[rd]);
                    check("R7 count flag", count_err, exp_cerr[rd]);
                end else begin
                    check("R9 unexpected done", 1, 0);
                end
                rd++;
            end else if (rd > 0 && rd <= wr) begin
                check("R9 mean held", avg_out, exp_avg[rd-1]);
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 busy", busy, 0);
        check("R10 done", done, 0);
        check("R10 avg", avg_out, 0);
        check("R10 dev", dev_out, 0);
        check("R10 pct", pct_out, 0);
        check("R10 zero flag", zero_avg_err, 0);
        check("R10 count flag", count_err, 0);
        rst_n = 1'b1;

        // R3 R6: constant lines over every pixel value, end strobe with the last pixel.
        for (int v = 0; v <= FS; v++) begin
            n_it = LP; eol_alone = 1'b0;
            for (int i = 0; i < LP; i++) begin it_d[i] = v; it_v[i] = 1; end
            send_line();
        end
        // R2 R4: ramps closed by a separate end strobe.
        for (int k = 1; k <= 5; k++) begin
            n_it = LP; eol_alone = 1'b1;
            for (int i = 0; i < LP; i++) begin it_d[i] = (i * k + k) % 16; it_v[i] = 1; end
            send_line();
        end
        // R4 R5: a single bright pixel on a dark line.
        n_it = LP; eol_alone = 1'b0;
        for (int i = 0; i < LP; i++) begin it_d[i] = (i == 3) ? 15 : 0; it_v[i] = 1; end
        send_line();
        // R1: pseudo-random lines with invalid slots carrying garbage data.
        for (int l = 0; l < 12; l++) begin
            n_it = 9; eol_alone = (l % 2 == 1);
            for (int i = 0; i < 9; i++) begin it_d[i] = rnd(); it_v[i] = (i % 3 != 1); end
            send_line();
        end
        // R7: short line.
        n_it = 4; eol_alone = 1'b0;
        it_d[0] = 3; it_d[1] = 9; it_d[2] = 1; it_d[3] = 12;
        for (int i = 0; i < 4; i++) it_v[i] = 1;
        send_line();
        // R7: long line whose extra pixels must not disturb the statistics.
        n_it = 8; eol_alone = 1'b0;
        for (int i = 0; i < 8; i++) begin it_d[i] = (i < LP) ? 5 : ((i == LP) ? 15 : 0); it_v[i] = 1; end
        send_line();
        // R2 R6: empty line, end strobe only.
        n_it = 0; eol_alone = 1'b1;
        send_line();
        // R8: garbage while busy must neither count nor close a line.
        n_it = LP; eol_alone = 1'b0;
        for (int i = 0; i < LP; i++) begin it_d[i] = 2 * i + 1; it_v[i] = 1; end
        send_line();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R8 busy after end strobe", busy, 1);
            smp_valid = 1'b1; smp_eol = 1'b1; smp_data = PW'(15);
        end
        idle();
        while (busy && cyc < LIMIT) @(negedge clk);
        // R9: this line follows a quiet gap; the lines before it start in the done cycle.
        n_it = LP; eol_alone = 1'b0;
        for (int i = 0; i < LP; i++) begin it_d[i] = 7 + (i % 2); it_v[i] = 1; end
        send_line();
        idle();

        while (rd < wr && cyc < LIMIT) @(negedge clk);
        repeat (5) @(negedge clk);
        check("R9 every line reported once", rd, wr);
        if (cyc >= LIMIT) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, LIMIT);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule